// File: doc/BRIEF.md
# I2C SDA Hold and Setup Timer

This block sits between the bit-level I2C sequencer and the pad drivers. It shifts SDA in time relative to SCL, counting every delay in system clock cycles. When the sequencer asks for a new SDA value at an SCL falling strobe, the block holds the old level for a programmed number of cycles before it presents the new one. On the receive side, it extends any SDA transition seen while SCL is high by a second programmed count, so short disturbances near the SCL edges are not taken as data changes.

When the block acts as a slave transmitter answering a read, it also holds SCL low after each SDA change for a setup count. It does this by lowering a release permit that the SCL driver obeys. The sequencer supplies the edge strobes, mode flags and requested level. The register file supplies a 24-bit hold word and an 8-bit setup word. The register file's default hold word is 1, which gives a one-cycle transmit hold.

Top module: `i2c_sda_timer`

## Requirements
- R1: Let H be hold_cfg[15:0] and N = max(H,1). When scl_fall is sampled high at clock edge k while enable is high, sda_req is captured and appears on sda_drive at edge k+N. sda_drive keeps its previous value until then.
- R2: A transmit hold field of 0 behaves exactly like 1. sda_drive never changes at the edge that samples scl_fall.
- R3: A new scl_fall that arrives while a hold is pending discards the pending value and restarts the count from the new strobe with the new sda_req.
- R4: Let E be hold_cfg[23:16]. With enable and scl_high high and tx_active low, a difference between sda_in and sda_rx first sampled at edge k is recognised on sda_rx at edge k+E, or at edge k when E is 0. Changes of sda_in while an extension is running are ignored.
- R5: When scl_high is low, tx_active is high, or enable is low, sda_rx equals sda_in delayed by one clock.
- R6: With slave_tx high, the edge at which a hold completes loads the setup count S = setup_cfg. scl_release stays low until edge k+N+S, and goes high at edge k+N when S is 0.
- R7: With slave_tx high, scl_release is low from the edge that samples scl_fall until the hold completes.
- R8: When slave_tx is low, scl_release is high.
- R9: While enable is low, all counters are cleared and scl_fall is ignored, sda_drive is 1 (released) and scl_release is 1. A hold that was pending when enable fell is never applied.
- R10: After reset, sda_drive, sda_rx and scl_release are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays count its periods |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts all counters |
| scl_fall | input | 1 | One-cycle strobe: SCL went from high to low |
| scl_high | input | 1 | Current SCL level is high |
| tx_active | input | 1 | Block is driving SDA (receive extension bypassed) |
| slave_tx | input | 1 | Serving a read request as slave transmitter |
| sda_req | input | 1 | SDA level requested by the sequencer |
| sda_in | input | 1 | Synchronised SDA level from the bus |
| hold_cfg | input | 24 | [15:0] transmit hold, [23:16] receive extension |
| setup_cfg | input | 8 | Setup delay before SCL may rise in slave transmit |
| sda_drive | output | 1 | Delayed SDA drive level (1 = released) |
| sda_rx | output | 1 | SDA level as recognised by the receiver |
| scl_release | output | 1 | Permit for the SCL driver to let SCL rise |

## Verification
The new SDA drive level is due max(H,1) cycles after the edge that samples the falling strobe. In slave transmit, the SCL permit goes low at that strobe edge and returns S cycles after the SDA change. A receive-side transition is due E cycles after the edge that first sees it, and the bypass path is due one cycle later. The bench drives every input on the falling clock edge and samples on the next falling edge, so each step covers exactly one rising edge. It compares the outputs after every step of a window against these counts, which catches a result that arrives one cycle early as well as one that arrives late.

// File: rtl/i2c_sda_timer_pkg.sv
package i2c_sda_timer_pkg;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;

    localparam int unsigned DEF_HOLD_TX_W = 16;
    localparam int unsigned DEF_HOLD_RX_W = 8;
    localparam int unsigned DEF_SETUP_W   = 8;

    // Zero hold is promoted to one so SDA never moves on the SCL falling edge.
    function automatic logic [31:0] at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/sdt_countdown.sv
module sdt_countdown
    import i2c_sda_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         done
);
    cd_state_e    state;
    logic [W-1:0] cnt;

    assign busy = (state == CD_RUN);
    assign done = busy && (cnt == {{(W-1){1'b0}}, 1'b1}) && !load && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= CD_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= CD_RUN;
            cnt   <= load_val;
        end else if (done) begin
            state <= CD_IDLE;
            cnt   <= '0;
        end else if (busy) begin
            cnt   <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdt_tx_hold.sv
module sdt_tx_hold
    import i2c_sda_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         scl_fall,
    input  logic         sda_req,
    input  logic [W-1:0] hold_cnt,
    output logic         sda_drive,
    output logic         hold_busy,
    output logic         apply
);
    logic         pend;
    logic         load;
    logic [W-1:0] eff;
    logic [31:0]  eff_wide;

    assign eff_wide = at_least_one(32'(hold_cnt));
    assign eff      = eff_wide[W-1:0];
    assign load     = enable && scl_fall;

    sdt_countdown #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (!enable),
        .load     (load),
        .load_val (eff),
        .busy     (hold_busy),
        .done     (apply)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b1;
            sda_drive <= 1'b1;
        end else if (!enable) begin
            pend      <= 1'b1;
            sda_drive <= 1'b1;
        end else begin
            if (load)  pend      <= sda_req;
            if (apply) sda_drive <= pend;
        end
    end
endmodule

// File: rtl/sdt_rx_extend.sv
module sdt_rx_extend #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         scl_high,
    input  logic         tx_active,
    input  logic         sda_in,
    input  logic [W-1:0] ext_cnt,
    output logic         sda_rx
);
    logic bypass;
    logic busy;
    logic done;
    logic differs;
    logic load;
    logic pend;

    assign bypass  = !enable || !scl_high || tx_active;
    assign differs = (sda_in != sda_rx);
    assign load    = !bypass && !busy && differs && (ext_cnt != '0);

    sdt_countdown #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (bypass),
        .load     (load),
        .load_val (ext_cnt),
        .busy     (busy),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_rx <= 1'b1;
            pend   <= 1'b1;
        end else if (bypass) begin
            sda_rx <= sda_in;
        end else if (done) begin
            sda_rx <= pend;
        end else if (load) begin
            pend   <= sda_in;
        end else if (!busy && differs) begin
            sda_rx <= sda_in;
        end
    end
endmodule

// File: rtl/sdt_setup_gate.sv
module sdt_setup_gate #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         slave_tx,
    input  logic         hold_busy,
    input  logic         apply,
    input  logic [W-1:0] setup_cnt,
    output logic         scl_release
);
    logic active;
    logic busy;
    logic done_unused;

    assign active = enable && slave_tx;

    sdt_countdown #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (!active),
        .load     (active && apply && (setup_cnt != '0)),
        .load_val (setup_cnt),
        .busy     (busy),
        .done     (done_unused)
    );

    assign scl_release = !(active && (hold_busy || busy));
endmodule

// File: rtl/i2c_sda_timer.sv
module i2c_sda_timer
    import i2c_sda_timer_pkg::*;
#(
    parameter int unsigned HOLD_TX_W = DEF_HOLD_TX_W,
    parameter int unsigned HOLD_RX_W = DEF_HOLD_RX_W,
    parameter int unsigned SETUP_W   = DEF_SETUP_W,
    localparam int unsigned HOLD_W   = HOLD_TX_W + HOLD_RX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               scl_fall,
    input  logic               scl_high,
    input  logic               tx_active,
    input  logic               slave_tx,
    input  logic               sda_req,
    input  logic               sda_in,
    input  logic [HOLD_W-1:0]  hold_cfg,
    input  logic [SETUP_W-1:0] setup_cfg,
    output logic               sda_drive,
    output logic               sda_rx,
    output logic               scl_release
);
    logic [HOLD_TX_W-1:0] tx_hold;
    logic [HOLD_RX_W-1:0] rx_ext;
    logic                 hold_busy;
    logic                 apply;

    assign tx_hold = hold_cfg[HOLD_TX_W-1:0];
    assign rx_ext  = hold_cfg[HOLD_W-1:HOLD_TX_W];

    sdt_tx_hold #(.W(HOLD_TX_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .scl_fall  (scl_fall),
        .sda_req   (sda_req),
        .hold_cnt  (tx_hold),
        .sda_drive (sda_drive),
        .hold_busy (hold_busy),
        .apply     (apply)
    );

    sdt_rx_extend #(.W(HOLD_RX_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .scl_high  (scl_high),
        .tx_active (tx_active),
        .sda_in    (sda_in),
        .ext_cnt   (rx_ext),
        .sda_rx    (sda_rx)
    );

    sdt_setup_gate #(.W(SETUP_W)) u_setup (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .slave_tx    (slave_tx),
        .hold_busy   (hold_busy),
        .apply       (apply),
        .setup_cnt   (setup_cfg),
        .scl_release (scl_release)
    );
endmodule

// File: rtl/i2c_sda_timer_chk.sv
module i2c_sda_timer_chk #(
    parameter int unsigned SETUP_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               scl_fall,
    input logic               scl_high,
    input logic               tx_active,
    input logic               slave_tx,
    input logic               sda_in,
    input logic [SETUP_W-1:0] setup_cfg,
    input logic               sda_drive,
    input logic               sda_rx,
    input logic               scl_release
);
    logic past_valid;

    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    // R2: no SDA change at the edge that samples the falling strobe
    a_r2_no_move_on_fall: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(enable) && $past(scl_fall)) |-> $stable(sda_drive));

    // R9: disabled state drives the released levels
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(enable)) |-> (sda_drive && scl_release));

    // R5: bypass path is a one-cycle delay of the bus level
    a_r5_rx_bypass: assert property (@(posedge clk) disable iff (rst)
        (past_valid && (!$past(enable) || !$past(scl_high) || $past(tx_active)))
        |-> (sda_rx == $past(sda_in)));

    // R8: no SCL stretching outside slave transmit
    a_r8_release_master: assert property (@(posedge clk) disable iff (rst)
        !slave_tx |-> scl_release);

    // R6: SDA change in slave transmit with a nonzero setup holds SCL low
    a_r6_setup_after_change: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(enable) && enable && $past(slave_tx) && slave_tx
         && (sda_drive != $past(sda_drive)) && ($past(setup_cfg) != '0))
        |-> !scl_release);
endmodule

bind i2c_sda_timer i2c_sda_timer_chk #(.SETUP_W(SETUP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .scl_fall    (scl_fall),
    .scl_high    (scl_high),
    .tx_active   (tx_active),
    .slave_tx    (slave_tx),
    .sda_in      (sda_in),
    .setup_cfg   (setup_cfg),
    .sda_drive   (sda_drive),
    .sda_rx      (sda_rx),
    .scl_release (scl_release)
);

// File: tb/tb_i2c_sda_timer.sv
module tb_i2c_sda_timer;
    logic        clk = 1'b0;
    logic        rst, enable, scl_fall, scl_high, tx_active, slave_tx, sda_req, sda_in;
    logic [23:0] hold_cfg;
    logic [7:0]  setup_cfg;
    logic        sda_drive, sda_rx, scl_release;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_sda_timer dut (
        .clk(clk), .rst(rst), .enable(enable), .scl_fall(scl_fall),
        .scl_high(scl_high), .tx_active(tx_active), .slave_tx(slave_tx),
        .sda_req(sda_req), .sda_in(sda_in), .hold_cfg(hold_cfg),
        .setup_cfg(setup_cfg), .sda_drive(sda_drive), .sda_rx(sda_rx),
        .scl_release(scl_release)
    );

    typedef struct packed {
        logic [15:0] hold;
        logic [7:0]  setup;
        logic        slave;
        logic        val;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{hold: 16'd1, setup: 8'd2, slave: 1'b1, val: 1'b0},
        '{hold: 16'd4, setup: 8'd3, slave: 1'b1, val: 1'b1},
        '{hold: 16'd0, setup: 8'd5, slave: 1'b1, val: 1'b0},
        '{hold: 16'd6, setup: 8'd0, slave: 1'b1, val: 1'b1},
        '{hold: 16'd2, setup: 8'd4, slave: 1'b0, val: 1'b0},
        '{hold: 16'd5, setup: 8'd1, slave: 1'b1, val: 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; scl_fall = 1'b0; scl_high = 1'b0; tx_active = 1'b0;
        slave_tx = 1'b0; sda_req = 1'b1; sda_in = 1'b1; hold_cfg = 24'd1; setup_cfg = 8'h64;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        chk("R10", "sda_drive", sda_drive, 1'b1);
        chk("R10", "sda_rx", sda_rx, 1'b1);
        chk("R10", "scl_release", scl_release, 1'b1);

        enable = 1'b1;
        tx_active = 1'b1;
        step();

        // Table walk: R1 R2 R6 R7 R8
        begin
            logic prev;
            prev = 1'b1;
            foreach (VECS[i]) begin
                int n, s;
                n = (VECS[i].hold == 16'd0) ? 1 : int'(VECS[i].hold);
                s = VECS[i].slave ? int'(VECS[i].setup) : 0;
                hold_cfg  = {8'd0, VECS[i].hold};
                setup_cfg = VECS[i].setup;
                slave_tx  = VECS[i].slave;
                sda_req   = VECS[i].val;
                scl_fall  = 1'b1;
                step();
                scl_fall  = 1'b0;
                sda_req   = ~VECS[i].val;
                // after step 1 the strobe edge has passed; R2 and R1 timing
                chk(VECS[i].hold == 16'd0 ? "R2" : "R1", "sda_drive at strobe edge", sda_drive, prev);
                chk(VECS[i].slave ? "R7" : "R8", "scl_release at strobe edge", scl_release, !VECS[i].slave);
                for (int st = 2; st <= n + s + 1; st++) begin
                    step();
                    chk("R1", "sda_drive window", sda_drive, (st >= n + 1) ? VECS[i].val : prev);
                    if (!VECS[i].slave)
                        chk("R8", "scl_release master", scl_release, 1'b1);
                    else if (st < n + 1)
                        chk("R7", "scl_release during hold", scl_release, 1'b0);
                    else
                        chk("R6", "scl_release setup", scl_release, st >= n + 1 + s);
                end
                prev = VECS[i].val;
                step();
            end
        end

        // R3 restart: sda_drive is 1 here
        slave_tx = 1'b0;
        hold_cfg = {8'd0, 16'd5};
        sda_req = 1'b0; scl_fall = 1'b1;
        step();
        scl_fall = 1'b0;
        step();
        sda_req = 1'b0; scl_fall = 1'b1;
        step();
        scl_fall = 1'b0; sda_req = 1'b1;
        for (int st = 2; st <= 6; st++) begin
            step();
            chk("R3", "sda_drive after restart", sda_drive, (st >= 6) ? 1'b0 : 1'b1);
        end

        // R4 receive extension with E=3, then E=0
        tx_active = 1'b0; scl_high = 1'b0; sda_in = 1'b1;
        hold_cfg = {8'd3, 16'd1};
        step(); step();
        scl_high = 1'b1; sda_in = 1'b0;
        for (int j = 1; j <= 4; j++) begin
            step();
            if (j == 2) sda_in = 1'b1;
            chk("R4", "sda_rx extended", sda_rx, (j >= 4) ? 1'b0 : 1'b1);
        end
        step();
        chk("R4", "sda_rx re-extends toward bus", sda_rx, 1'b0);
        repeat (3) step();
        chk("R4", "sda_rx settles", sda_rx, 1'b1);
        hold_cfg = {8'd0, 16'd1};
        sda_in = 1'b0;
        step();
        chk("R4", "sda_rx zero extension", sda_rx, 1'b0);

        // R5 bypass paths
        scl_high = 1'b0; sda_in = 1'b1;
        step();
        chk("R5", "sda_rx scl low", sda_rx, 1'b1);
        hold_cfg = {8'd3, 16'd1};
        scl_high = 1'b1; tx_active = 1'b1; sda_in = 1'b0;
        step();
        chk("R5", "sda_rx while transmitting", sda_rx, 1'b0);

        // R9 disable aborts pending hold and setup
        tx_active = 1'b1; scl_high = 1'b0; slave_tx = 1'b1;
        hold_cfg = {8'd0, 16'd1}; setup_cfg = 8'd0;
        sda_req = 1'b1; scl_fall = 1'b1;
        step();
        scl_fall = 1'b0;
        step();
        chk("R9", "sda_drive before disable test", sda_drive, 1'b1);
        hold_cfg = {8'd0, 16'd6}; setup_cfg = 8'd4;
        sda_req = 1'b0; scl_fall = 1'b1;
        step();
        scl_fall = 1'b0;
        step();
        enable = 1'b0;
        step();
        chk("R9", "sda_drive disabled", sda_drive, 1'b1);
        chk("R9", "scl_release disabled", scl_release, 1'b1);
        sda_req = 1'b0; scl_fall = 1'b1;
        step();
        scl_fall = 1'b0;
        enable = 1'b1;
        for (int st = 1; st <= 8; st++) begin
            step();
            chk("R9", "sda_drive stays released", sda_drive, 1'b1);
            chk("R9", "scl_release stays high", scl_release, 1'b1);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule